// File: doc/BRIEF.md
# Interrupt Source Unit with Edge and Level Sources

This block owns a fixed set of interrupt sources. Each source is either edge-style (a one-cycle event pulse on its line) or level-style (the line stays high while the condition lasts). A parameter fixes each source's style, and reset does not change it. Software configures each source through a write port with a destination server, an 8-bit priority and a saved priority. A priority of 8'hFF masks the source.

The unit keeps a status word for each source. For edge sources the word holds rejected and masked-pending bits. For level sources it holds asserted and sent bits. The unit uses these bits to decide when a source is offered, or offered again, to a single presentation controller. Offers leave on a valid/ready stream as a global interrupt number (the base number plus the local index), the priority, the saved priority and the server.

The presentation controller reports back in three ways:
- It rejects an interrupt by number.
- It signals end-of-interrupt by number.
- It pulses a resend request that sweeps every source.

Top module: `irq_source_unit`

## Requirements
- R1: After reset no offer is valid, and every source has priority 8'hFF (masked) with clear status. An event on an edge source therefore produces no offer until that source is configured.
- R2: An event pulse on an unmasked edge source at local index i produces an offer with `pres_num` = BASE+i. The offer carries that source's configured priority and server.
- R3: An event on a masked edge source records masked-pending and produces no offer. A later configuration write with a priority other than 8'hFF clears masked-pending and offers the source. A write that keeps 8'hFF leaves it pending. No offer ever carries priority 8'hFF.
- R4: A reject of an edge source sets its rejected bit. The next resend clears the bit and offers the source once if it is unmasked. A further resend produces nothing. If the source is masked at resend time, the bit is cleared and nothing is offered.
- R5: A level source follows its line. When the line changes, and the source is unmasked, asserted and not yet sent, it is offered once and marked sent. A line that stays high is not offered again.
- R6: A reject of a level source clears its sent bit without offering it. A following resend offers it again only if the line is still high.
- R7: End-of-interrupt for a level source clears its sent bit, so the next resend offers it again if the line is still high. End-of-interrupt for an edge source changes nothing.
- R8: Reject and end-of-interrupt numbers outside BASE..BASE+N_SRC-1 are ignored.
- R9: When several sources wait, the lowest local index is offered first. While `pres_valid` is high and `pres_ready` is low, `pres_num`, `pres_prio`, `pres_saved` and `pres_server` hold steady.
- R10: A configuration write that unmasks a level source whose line is high and which is not sent offers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | N_SRC | Per-source lines: pulses for edge sources, levels for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | 8 | New priority (8'hFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject indication strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend sweep request |
| pres_valid | output | 1 | Offer valid |
| pres_ready | input | 1 | Presentation controller takes the offer |
| pres_num | output | NUM_W | Global interrupt number offered |
| pres_prio | output | 8 | Priority of the offer |
| pres_saved | output | 8 | Saved priority of the offer |
| pres_server | output | SRV_W | Server of the offer |

## Verification
Every input is captured into the source status on one clock edge. The output stage loads the offer on the following edge, so any offer caused by a stimulus appears two edges after the stimulus is applied. When an offer is accepted, the next waiting source is loaded on that same edge. The bench drives inputs just after a falling edge, keeps them for one cycle, waits one more cycle and samples on a falling edge, where the result is due. For the "nothing happens" cases, it samples at that same point, where an offer would otherwise have appeared. The hold rule is checked across several stalled cycles, with a lower-index source arriving during the stall.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic rejected;  // edge: refused, waits for a resend sweep
    logic mpend;     // edge: event seen while masked
    logic asserted;  // level: registered copy of the line
    logic sent;      // level: offered and not yet completed
    logic req;       // waiting to be offered
  } src_stat_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0,
  parameter int SRV_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             take,
  output logic             want,
  output logic [7:0]       prio_o,
  output logic [7:0]       saved_o,
  output logic [SRV_W-1:0] server_o
);
  src_stat_t        st, nx;
  logic [7:0]       prio_q, prio_n, saved_q;
  logic [SRV_W-1:0] server_q;
  logic             line_chg;

  assign prio_n   = cfg_hit ? cfg_prio : prio_q;
  assign line_chg = line != st.asserted;

  always_comb begin
    nx = st;
    if (take) nx.req = 1'b0;
    if (IS_LEVEL) begin
      nx.asserted = line;
      if (rej_hit || eoi_hit) nx.sent = 1'b0;
      if ((line_chg || cfg_hit || resend) && prio_n != PRIO_OFF && line && !nx.sent) begin
        nx.sent = 1'b1;
        nx.req  = 1'b1;
      end
    end else begin
      if (line) begin
        if (prio_n == PRIO_OFF) nx.mpend = 1'b1;
        else                    nx.req   = 1'b1;
      end
      if (cfg_hit && st.mpend && cfg_prio != PRIO_OFF) begin
        nx.mpend = 1'b0;
        nx.req   = 1'b1;
      end
      if (resend && st.rejected) begin
        nx.rejected = 1'b0;
        if (prio_n != PRIO_OFF) nx.req = 1'b1;
      end
      if (rej_hit) nx.rejected = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      prio_q   <= PRIO_OFF;
      saved_q  <= PRIO_OFF;
      server_q <= '0;
    end else begin
      st     <= nx;
      prio_q <= prio_n;
      if (cfg_hit) begin
        saved_q  <= cfg_saved;
        server_q <= cfg_server;
      end
    end
  end

  assign want     = st.req && prio_q != PRIO_OFF;
  assign prio_o   = prio_q;
  assign saved_o  = saved_q;
  assign server_o = server_q;

  assert_mpend_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_LEVEL && $rose(st.mpend)) |-> prio_q == PRIO_OFF);
  assert_sent_asserted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEVEL && $rose(st.sent)) |-> st.asserted);
endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] want,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_source_unit.sv
module irq_source_unit
  import irq_src_pkg::*;
#(
  parameter int               N_SRC     = 8,
  parameter int               NUM_W     = 12,
  parameter int               BASE      = 16,
  parameter int               SRV_W     = 4,
  parameter logic [N_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int              IDX_W     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_line,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             pres_valid,
  input  logic             pres_ready,
  output logic [NUM_W-1:0] pres_num,
  output logic [7:0]       pres_prio,
  output logic [7:0]       pres_saved,
  output logic [SRV_W-1:0] pres_server
);
  localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] CNT_V  = NUM_W'(N_SRC);

  logic [NUM_W-1:0] rej_rel, eoi_rel;
  logic             rej_ok, eoi_ok, load, any;
  logic [IDX_W-1:0] idx;
  logic [N_SRC-1:0] want, take;
  logic [7:0]       prio_a  [N_SRC];
  logic [7:0]       saved_a [N_SRC];
  logic [SRV_W-1:0] srv_a   [N_SRC];

  assign rej_rel = rej_num - BASE_V;
  assign eoi_rel = eoi_num - BASE_V;
  assign rej_ok  = rej_valid && rej_num >= BASE_V && rej_rel < CNT_V;
  assign eoi_ok  = eoi_valid && eoi_num >= BASE_V && eoi_rel < CNT_V;
  assign load    = !pres_valid || pres_ready;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_slot #(.IS_LEVEL(LEVEL_MAP[g]), .SRV_W(SRV_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .line       (irq_line[g]),
      .cfg_hit    (cfg_we && cfg_idx == IDX_W'(g)),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_saved  (cfg_saved),
      .rej_hit    (rej_ok && rej_rel == NUM_W'(g)),
      .eoi_hit    (eoi_ok && eoi_rel == NUM_W'(g)),
      .resend     (resend),
      .take       (take[g]),
      .want       (want[g]),
      .prio_o     (prio_a[g]),
      .saved_o    (saved_a[g]),
      .server_o   (srv_a[g])
    );
    assign take[g] = load && any && idx == IDX_W'(g);
  end

  irq_src_pick #(.N_SRC(N_SRC)) u_pick (
    .want (want),
    .any  (any),
    .idx  (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_valid  <= 1'b0;
      pres_num    <= '0;
      pres_prio   <= PRIO_OFF;
      pres_saved  <= PRIO_OFF;
      pres_server <= '0;
    end else if (load) begin
      pres_valid <= any;
      if (any) begin
        pres_num    <= BASE_V + NUM_W'(idx);
        pres_prio   <= prio_a[idx];
        pres_saved  <= saved_a[idx];
        pres_server <= srv_a[idx];
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && !pres_ready) |=> (pres_valid && $stable(pres_num) && $stable(pres_prio)
                                     && $stable(pres_server)));
  assert_no_masked_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != PRIO_OFF);
endmodule

// File: tb/sim_irq_source_unit.sv
module sim_irq_source_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_line = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_server = '0;
  logic [7:0]  cfg_prio = '0, cfg_saved = '0;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0, pres_ready = 1'b0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic        pres_valid;
  logic [11:0] pres_num;
  logic [7:0]  pres_prio, pres_saved;
  logic [3:0]  pres_server;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_source_unit u0 (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic want_idle(input string tag);
    chk(!pres_valid, tag, int'(pres_valid), 0);
  endtask

  task automatic want_offer(input string tag, input int num, input int prio);
    chk(pres_valid, {tag, " valid"}, int'(pres_valid), 1);
    chk(int'(pres_num) == num, {tag, " num"}, int'(pres_num), num);
    chk(int'(pres_prio) == prio, {tag, " prio"}, int'(pres_prio), prio);
  endtask

  task automatic accept; pres_ready = 1'b1; tick; pres_ready = 1'b0; endtask
  task automatic settle; tick; endtask

  task automatic fire(input int i); irq_line[i] = 1'b1; tick; irq_line[i] = 1'b0; settle; endtask
  task automatic cfg(input int i, input int prio, input int srv);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_prio = 8'(prio); cfg_saved = 8'(prio + 1);
    cfg_server = 4'(srv); tick; cfg_we = 1'b0; settle;
  endtask
  task automatic rej(input int n); rej_valid = 1'b1; rej_num = 12'(n); tick; rej_valid = 1'b0; settle; endtask
  task automatic eoi(input int n); eoi_valid = 1'b1; eoi_num = 12'(n); tick; eoi_valid = 1'b0; settle; endtask
  task automatic sweep; resend = 1'b1; tick; resend = 1'b0; settle; endtask
  task automatic set_line(input int i, input bit v); irq_line[i] = v; tick; settle; endtask

  task automatic t_reset_and_masked;
    want_idle("R1 reset");
    fire(0);
    want_idle("R1 masked edge after reset");
    cfg(0, 5, 1);
    want_offer("R3 unmask pending", 16, 5);
    accept; want_idle("R3 after accept");
  endtask

  task automatic t_edge_basic;
    cfg(1, 3, 2);
    want_idle("R2 config alone");
    fire(1);
    want_offer("R2 edge", 17, 3);
    chk(pres_server == 4'd2, "R2 server", int'(pres_server), 2);
    chk(pres_saved == 8'd4, "R2 saved", int'(pres_saved), 4);
    accept;
  endtask

  task automatic t_masked_pending;
    fire(2);
    cfg(2, 255, 0);
    want_idle("R3 still masked");
    cfg(2, 7, 0);
    want_offer("R3 pending released", 18, 7);
    accept;
  endtask

  task automatic t_edge_reject;
    rej(17); want_idle("R4 reject");
    sweep;   want_offer("R4 resend", 17, 3);
    accept;
    sweep;   want_idle("R4 second resend");
    rej(17); cfg(1, 255, 2); sweep;
    want_idle("R4 masked at resend");
    cfg(1, 3, 2);
    want_idle("R4 rejected cleared");
  endtask

  task automatic t_level;
    cfg(4, 9, 0);
    set_line(4, 1'b1);
    want_offer("R5 level", 20, 9);
    accept; tick; tick;
    want_idle("R5 held high once");
    eoi(20); want_idle("R7 eoi no event");
    sweep;   want_offer("R7 resend after eoi", 20, 9);
    accept;
    eoi(16); sweep; want_idle("R7 edge eoi no effect");
    rej(20); want_idle("R6 reject");
    sweep;   want_offer("R6 resend high", 20, 9);
    accept;
    rej(20); set_line(4, 1'b0); sweep;
    want_idle("R6 resend low");
  endtask

  task automatic t_level_cfg;
    set_line(5, 1'b1);
    want_idle("R10 masked level");
    cfg(5, 2, 3);
    want_offer("R10 unmask level", 21, 2);
    accept;
  endtask

  task automatic t_range;
    set_line(4, 1'b1);
    want_offer("R8 setup", 20, 9);
    accept;
    eoi(24); eoi(15); sweep;
    want_idle("R8 eoi out of range");
    rej(24); rej(15); sweep;
    want_idle("R8 reject out of range");
  endtask

  task automatic t_arbitrate;
    cfg(3, 4, 0);
    irq_line[1] = 1'b1; irq_line[3] = 1'b1; tick;
    irq_line[1] = 1'b0; irq_line[3] = 1'b0; settle;
    want_offer("R9 lowest first", 17, 3);
    fire(0); tick;
    want_offer("R9 held under stall", 17, 3);
    accept; want_offer("R9 next lowest", 16, 5);
    accept; want_offer("R9 last", 19, 4);
    accept; want_idle("R9 drained");
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    t_reset_and_masked;
    t_edge_basic;
    t_masked_pending;
    t_edge_reject;
    t_level;
    t_level_cfg;
    t_range;
    t_arbitrate;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule